// File: doc/BRIEF.md
# Gold Sequence Scrambling Bit Generator

This block produces the pseudo-random scrambling bit stream of 5G NR. Two 31-bit linear feedback shift registers run side by side. One always starts from a fixed seed. The other starts from a 31-bit initialization word. Each output bit is the XOR of the two low-end cells, read before that step's shift.

A start pulse seeds both registers. The initialization word comes either from the `init_word` port or from a built-in helper, which forms it from an RNTI, a codeword index and a scrambling identity. In normal mode the block then performs 1600 discarded shifts, one per clock, with `busy` high. After that it offers one bit at a time over a valid/ready serial output. A skip mode leaves out the warm-up for bring-up and teaching use; the bits it produces are not the standard sequence.

A new start pulse may arrive at any time. It reseeds both registers and restarts the warm-up.

Top module: `gold_scrambler`

## Requirements
- R1: After reset is released, `out_valid` and `busy` are both 0 until the first `start` pulse.
- R2: On `start`, register A is set to 1 in cell 0 and 0 in cells 1 to 30. Register B receives the selected 31-bit word, with word bit i in cell i.
- R3: Every offered bit `out_bit` equals cell 0 of A XOR cell 0 of B. The bit is taken before the shift of that step.
- R4: When A steps, its cells move one place toward cell 0, and the XOR of cells 0 and 3 enters cell 30.
- R5: When B steps, it moves the same way, and the XOR of cells 0, 1, 2 and 3 enters cell 30.
- R6: With `skip_warmup` = 0 at `start`, `busy` is high for exactly 1600 cycles after the start edge, with one shift per cycle. `out_valid` stays 0 during that time, and the first offered bit comes after those 1600 shifts.
- R7: With `skip_warmup` = 1 at `start`, `busy` stays 0 and `out_valid` is 1 in the next cycle. The first offered bit comes from the seeded state with no shift.
- R8: The registers step only on a cycle with `out_valid` and `out_ready` both high, or during warm-up. While `out_ready` is 0, `out_bit` and `out_valid` hold.
- R9: A `start` pulse during warm-up or mid-stream reseeds both registers and restarts the warm-up. It takes priority over a shift or handshake in the same cycle.
- R10: With `use_ids` = 1, the initialization word is `rnti`·2^15 + `cw_idx`·2^14 + `scr_id`; for example, RNTI 1, index 0 and ID 0 give 32768. With `use_ids` = 0, it is `init_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Single-cycle pulse that seeds the registers |
| skip_warmup | input | 1 | Sampled with `start`: 1 leaves out the 1600-shift warm-up |
| use_ids | input | 1 | Sampled with `start`: 1 takes the word from the helper |
| init_word | input | 31 | Direct initialization word |
| rnti | input | 16 | RNTI for the helper |
| cw_idx | input | 1 | Codeword index, 0 or 1, for the helper |
| scr_id | input | 10 | Scrambling identity for the helper |
| out_ready | input | 1 | Consumer accepts the offered bit |
| out_valid | output | 1 | A scrambling bit is offered |
| out_bit | output | 1 | The offered scrambling bit |
| busy | output | 1 | Warm-up in progress |

## Verification
The assertions assume the following about the inputs:
- `start` is a pulse.
- The seed-source inputs are steady in the cycle in which they are sampled.
- `out_ready` is free to toggle, but changes only between clock edges.

The stimulus drives every input on the falling edge and holds `start` high for exactly one cycle. It varies `out_ready` in a fixed irregular pattern, so that hold cycles fall both in the middle of the stream and next to a restart. Expected streams come from a bench model that runs the two recurrences directly. The model is exercised with a zero word, the all-ones word and words formed by the helper, both with and without the warm-up.

// File: rtl/gold_pkg.sv
`timescale 1ns/1ps
package gold_pkg;
  localparam int unsigned LFSR_W   = 31;
  localparam int unsigned WARM_N   = 1600;
  localparam int unsigned RNTI_W   = 16;
  localparam int unsigned ID_W     = 10;
  localparam int unsigned RNTI_SH  = 15;
  localparam int unsigned CW_SH    = 14;
  localparam logic [LFSR_W-1:0] A_SEED   = LFSR_W'(1);
  localparam logic [LFSR_W-1:0] A_TAPS   = LFSR_W'(4'b1001);
  localparam logic [LFSR_W-1:0] B_TAPS   = LFSR_W'(4'b1111);
endpackage

// File: rtl/gold_seed_mux.sv
`timescale 1ns/1ps
module gold_seed_mux
  import gold_pkg::*;
(
  input  logic              use_ids,
  input  logic [LFSR_W-1:0] init_word,
  input  logic [RNTI_W-1:0] rnti,
  input  logic              cw_idx,
  input  logic [ID_W-1:0]   scr_id,
  output logic [LFSR_W-1:0] seed
);
  logic [LFSR_W-1:0] formed;

  always_comb begin
    formed = (LFSR_W'(rnti) << RNTI_SH) + (LFSR_W'(cw_idx) << CW_SH) + LFSR_W'(scr_id);
    seed   = use_ids ? formed : init_word;
  end
endmodule

// File: rtl/gold_lfsr.sv
`timescale 1ns/1ps
module gold_lfsr #(
  parameter int unsigned        W    = 31,
  parameter logic [W-1:0]       TAPS = W'(9)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         fb;

  always_comb begin
    fb  = ^(q & TAPS);
    q_d = q;
    if (load)     q_d = seed;
    else if (adv) q_d = {fb, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  p_load_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(seed));
  p_shift_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> q[W-2:0] == $past(q[W-1:1]));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(q));
endmodule

// File: rtl/gold_warm_ctrl.sv
`timescale 1ns/1ps
module gold_warm_ctrl #(
  parameter int unsigned WARM = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic skip,
  input  logic ready,
  output logic busy,
  output logic valid,
  output logic adv
);
  localparam int unsigned CW = $clog2(WARM + 1);

  logic [CW-1:0] cnt, cnt_d;
  logic          seeded, seeded_d;

  always_comb begin
    cnt_d    = cnt;
    seeded_d = seeded;
    if (start) begin
      cnt_d    = skip ? '0 : CW'(WARM);
      seeded_d = 1'b1;
    end else if (cnt != '0) begin
      cnt_d = cnt - 1'b1;
    end
  end

  always_comb begin
    busy  = (cnt != '0);
    valid = seeded && !busy;
    adv   = !start && (busy || (valid && ready));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      seeded <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      seeded <= seeded_d;
    end
  end

  p_warm_begin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !skip) |=> busy && !valid);
  p_warm_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> cnt == $past(cnt) - 1'b1);
  p_skip_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && skip) |=> valid && !busy);
  p_start_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !adv);
endmodule

// File: rtl/gold_scrambler.sv
`timescale 1ns/1ps
module gold_scrambler
  import gold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              skip_warmup,
  input  logic              use_ids,
  input  logic [LFSR_W-1:0] init_word,
  input  logic [RNTI_W-1:0] rnti,
  input  logic              cw_idx,
  input  logic [ID_W-1:0]   scr_id,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_bit,
  output logic              busy
);
  logic [1:0]        rst_sync;
  logic              rst_q_n;
  logic [LFSR_W-1:0] seed_b;
  logic              adv;
  logic [LFSR_W-1:0] reg_a, reg_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  gold_seed_mux u_seed (
    .use_ids(use_ids), .init_word(init_word), .rnti(rnti),
    .cw_idx(cw_idx), .scr_id(scr_id), .seed(seed_b)
  );

  gold_warm_ctrl #(.WARM(WARM_N)) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .start(start), .skip(skip_warmup),
    .ready(out_ready), .busy(busy), .valid(out_valid), .adv(adv)
  );

  for (genvar g = 0; g < 2; g++) begin : g_reg
    localparam logic [LFSR_W-1:0] TP = (g == 0) ? A_TAPS : B_TAPS;
    logic [LFSR_W-1:0] sd, qq;
    assign sd = (g == 0) ? A_SEED : seed_b;
    gold_lfsr #(.W(LFSR_W), .TAPS(TP)) u_lfsr (
      .clk(clk), .rst_n(rst_q_n), .load(start), .seed(sd), .adv(adv), .q(qq)
    );
  end
  assign reg_a = g_reg[0].qq;
  assign reg_b = g_reg[1].qq;

  assign out_bit = reg_a[0] ^ reg_b[0];

  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !out_ready && !start) |=> out_valid && $stable(out_bit));
  p_a_seeded_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    start |=> reg_a == A_SEED);
  p_no_offer_busy_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy |-> !out_valid);
endmodule

// File: tb/test_gold_scrambler.sv
`timescale 1ns/1ps
module test_gold_scrambler;
  localparam int NB = 48;
  // vector: {use_ids, skip, rnti[15:0], cw, id[9:0], word[30:0]}
  localparam int NV = 6;
  localparam logic [59:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'd0,      1'b0, 10'd0,   31'd0},
    {1'b1, 1'b0, 16'd1,      1'b0, 10'd0,   31'd0},
    {1'b0, 1'b1, 16'd0,      1'b0, 10'd0,   31'h7FFFFFFF},
    {1'b0, 1'b0, 16'd0,      1'b0, 10'd0,   31'h0012345},
    {1'b1, 1'b1, 16'hABCD,   1'b1, 10'd501, 31'h5555},
    {1'b0, 1'b1, 16'd0,      1'b0, 10'd0,   31'd0}
  };

  logic        clk = 0, rst_n = 0, start = 0, skip_warmup = 0, use_ids = 0;
  logic [30:0] init_word = '0;
  logic [15:0] rnti = '0;
  logic        cw_idx = 0;
  logic [9:0]  scr_id = '0;
  logic        out_ready = 0;
  logic        out_valid, out_bit, busy;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  gold_scrambler i_gold_scrambler (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] model(input logic [30:0] w, input bit skip);
    logic [30:0] a = 31'd1, b = w;
    logic [NB-1:0] r = '0;
    if (!skip)
      for (int i = 0; i < 1600; i++) begin
        a = {a[0]^a[3], a[30:1]};
        b = {b[0]^b[1]^b[2]^b[3], b[30:1]};
      end
    for (int i = 0; i < NB; i++) begin
      r[i] = a[0] ^ b[0];
      a = {a[0]^a[3], a[30:1]};
      b = {b[0]^b[1]^b[2]^b[3], b[30:1]};
    end
    return r;
  endfunction

  task automatic pulse_start(input logic [59:0] v);
    @(negedge clk);
    {use_ids, skip_warmup, rnti, cw_idx, scr_id, init_word} = v;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // counts busy cycles (sampled right after start), then collects n bits
  task automatic run_stream(input logic [NB-1:0] exp, input int n,
                            input string req, output int busy_cnt);
    int k = 0, cyc = 0;
    busy_cnt = 0;
    while (busy) begin
      busy_cnt++;
      chk(!out_valid, "R6 valid low while busy", out_valid, 0);
      @(negedge clk);
    end
    while (k < n && cyc < 400) begin
      if (out_valid) chk(out_bit == exp[k], req, out_bit, exp[k]);
      out_ready = ((cyc % 5) != 2) && ((cyc % 7) != 4);
      if (out_valid && out_ready) k++;
      cyc++;
      @(negedge clk);
    end
    out_ready = 0;
    chk(k == n, "R8 stream completed", k, n);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bc;
    logic [30:0] w;
    logic [NB-1:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(out_valid == 0, "R1 reset valid", out_valid, 0);
    chk(busy == 0, "R1 reset busy", busy, 0);

    // R10 helper check: RNTI 1 -> 32768 (vector 1 compared against model of 32768)
    for (int v = 0; v < NV; v++) begin
      w = VEC[v][59] ? (31'(VEC[v][57:42]) * 31'd32768 + 31'(VEC[v][41]) * 31'd16384
                        + 31'(VEC[v][40:31])) : VEC[v][30:0];
      if (v == 1) chk(w == 31'd32768, "R10 helper word", w, 32768);
      e = model(w, VEC[v][58]);
      pulse_start(VEC[v]);
      run_stream(e, NB, "R3 R4 R5 R10 stream bit", bc);
      chk(bc == (VEC[v][58] ? 0 : 1600), "R6 R7 busy length", bc, VEC[v][58] ? 0 : 1600);
    end

    // R2 R7: zero word, no warm-up -> A alone: 1 then zeros
    pulse_start({1'b0, 1'b1, 16'd0, 1'b0, 10'd0, 31'd0});
    chk(out_valid == 1 && out_bit == 1, "R2 R7 first bit", out_bit, 1);

    // R8 hold: ready low keeps bit steady for several cycles
    out_ready = 0;
    pulse_start({1'b0, 1'b1, 16'd0, 1'b0, 10'd0, 31'h1357});
    e = model(31'h1357, 1);
    repeat (5) begin
      @(negedge clk);
      chk(out_valid && out_bit == e[0], "R8 hold stall", out_bit, e[0]);
    end

    // R9 restart mid-stream with ready high in the same cycle
    out_ready = 1;
    repeat (3) @(negedge clk);
    e = model(31'h2468, 1);
    pulse_start({1'b0, 1'b1, 16'd0, 1'b0, 10'd0, 31'h2468});
    out_ready = 0;
    run_stream(e, 20, "R9 restart mid-stream", bc);

    // R9 restart during warm-up restarts the count
    pulse_start({1'b0, 1'b0, 16'd0, 1'b0, 10'd0, 31'h0777});
    repeat (500) @(negedge clk);
    chk(busy == 1, "R9 still warming", busy, 1);
    e = model(31'h0ABC, 0);
    pulse_start({1'b0, 1'b0, 16'd0, 1'b0, 10'd0, 31'h0ABC});
    run_stream(e, 24, "R9 restart in warm-up", bc);
    chk(bc == 1600, "R9 R6 warm-up restarted", bc, 1600);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule